// File: doc/BRIEF.md
# Addressable Tap Shift Register

A single-bit delay line made of a chain of 16 register stages. A serial bit enters stage 0 on every clock edge where the clock enable is high, and each stage passes its value on to the next. A 4-bit tap address picks which stage drives the data output, so the delay can be set anywhere from 1 to 16 enabled clocks. The delay can be changed at run time by changing the address, without any other reconfiguration.

The tap read does not pass through a register, so a new address shows at the output within the same cycle. A separate chain output always carries the last stage, whatever the address. Several units can then be joined end to end to build longer delays. An active-low asynchronous reset clears every stage to 0, which is also the power-up state.

Top module: `srl_tap_delay`

## Requirements
- R1: While rst_ni is low, every stage is 0, so q_o and cascade_o read 0 for every value of addr_i.
- R2: On each rising clk_i edge with en_i high, stage 0 takes d_i and stage k takes the old value of stage k-1.
- R3: On a rising edge with en_i low, no stage changes, and q_o and cascade_o keep their values for every address.
- R4: q_o follows addr_i combinationally. After an address change it shows the newly selected stage in the same cycle, with no clock edge.
- R5: cascade_o always shows stage 15, which is d_i as sampled 16 enabled edges earlier, whatever addr_i holds.
- R6: With addr_i = 0, q_o equals the d_i sampled at the most recent enabled edge (a delay of one).
- R7: With addr_i = a, q_o equals the d_i sampled a+1 enabled edges earlier. Edges with en_i low are not counted. Before a+1 enabled edges have occurred since reset, q_o reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous active-low clear of all stages |
| en_i | input | 1 | Clock enable for shifting |
| d_i | input | 1 | Serial data input |
| addr_i | input | 4 | Tap select; 0 selects stage 0 |
| q_o | output | 1 | Selected tap output |
| cascade_o | output | 1 | Last stage, for chaining |

## Verification
A shift and an address change can occur in the same cycle. The output then has to reflect both the newly shifted contents and the new tap at once. The bench provokes this after every clock edge by sweeping all 16 addresses inside the cycle that follows, which covers both enabled and held edges. Each reading is compared with a log of enabled input bits indexed by count of enabled edges, and cascade_o is checked at every address step to confirm that it ignores the tap.

// File: rtl/srl_pkg.sv
package srl_pkg;
  parameter int unsigned SRL_DEPTH = 16;
endpackage

// File: rtl/srl_stage_chain.sv
module srl_stage_chain #(
  parameter int unsigned DEPTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             d_i,
  output logic [DEPTH-1:0] stage_o
);
  for (genvar k = 0; k < DEPTH; k++) begin : g_stage
    logic nxt;
    if (k == 0) begin : g_head
      assign nxt = d_i;
    end else begin : g_body
      assign nxt = stage_o[k-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   stage_o[k] <= 1'b0;
      else if (en_i) stage_o[k] <= nxt;
    end
  end
endmodule

// File: rtl/srl_tap_mux.sv
module srl_tap_mux #(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned ADDR_W = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0]  stage_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              q_o
);
  always_comb begin
    q_o = 1'b0;
    for (int k = 0; k < DEPTH; k++) begin
      if (int'(addr_i) == k) q_o = stage_i[k];
    end
  end
endmodule

// File: rtl/srl_tap_delay.sv
module srl_tap_delay #(
  parameter int unsigned DEPTH  = srl_pkg::SRL_DEPTH,
  parameter int unsigned ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              d_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              q_o,
  output logic              cascade_o
);
  logic [DEPTH-1:0] stage_q;

  srl_stage_chain #(.DEPTH(DEPTH)) u_chain (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .d_i     (d_i),
    .stage_o (stage_q)
  );

  srl_tap_mux #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_mux (
    .stage_i (stage_q),
    .addr_i  (addr_i),
    .q_o     (q_o)
  );

  assign cascade_o = stage_q[DEPTH-1];
endmodule

// File: rtl/srl_tap_delay_chk.sv
module srl_tap_delay_chk #(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned ADDR_W = $clog2(DEPTH)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic              d_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              q_o,
  input logic              cascade_o,
  input logic [DEPTH-1:0]  stage_i
);
  assert_clear_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (q_o == 1'b0 && cascade_o == 1'b0 && stage_i == '0));

  assert_shift_head_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> stage_i[0] == $past(d_i));

  assert_shift_body_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> stage_i[DEPTH-1:1] == $past(stage_i[DEPTH-2:0]));

  assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> ($stable(stage_i) && $stable(cascade_o)));

  assert_cascade_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> cascade_o == $past(stage_i[DEPTH-2]));

  assert_first_tap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && addr_i == '0) |=> (addr_i != '0 || q_o == $past(d_i)));
endmodule

bind srl_tap_delay srl_tap_delay_chk #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .en_i      (en_i),
  .d_i       (d_i),
  .addr_i    (addr_i),
  .q_o       (q_o),
  .cascade_o (cascade_o),
  .stage_i   (stage_q)
);

// File: tb/srl_tap_delay_test.sv
module srl_tap_delay_test;
  localparam int CLK_P = 40;
  localparam int DEPTH = 16;
  localparam int LOG_N = 1024;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b1;
  logic       en_i = 1'b0;
  logic       d_i = 1'b0;
  logic [3:0] addr_i = '0;
  logic       q_o, cascade_o;

  int errors = 0;
  int checks = 0;
  int n_en = 0;
  logic log_q [LOG_N];
  bit done = 0;

  srl_tap_delay uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .d_i(d_i),
    .addr_i(addr_i), .q_o(q_o), .cascade_o(cascade_o)
  );

  always #(CLK_P/2) clk_i = ~clk_i;

  function automatic logic expect_at(int dly);
    return (n_en >= dly) ? log_q[n_en - dly] : 1'b0;
  endfunction

  task automatic check(string req, logic act, logic exp_v);
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s t=%0t addr=%0d n=%0d actual=%b expected=%b",
               req, $time, addr_i, n_en, act, exp_v);
    end
  endtask

  // sweep all taps within one cycle: R4 (same-cycle tap), R6/R7 delay, R5 cascade
  task automatic sweep(string req);
    for (int a = 0; a < DEPTH; a++) begin
      addr_i = 4'(a);
      #1;
      check(a == 0 ? "R6" : req, q_o, expect_at(a + 1));
      check("R5", cascade_o, expect_at(DEPTH));
    end
  endtask

  task automatic step(logic en_v, logic d_v, string req);
    @(negedge clk_i);
    en_i = en_v;
    d_i  = d_v;
    @(posedge clk_i);
    if (en_v) begin
      log_q[n_en] = d_v;
      n_en++;
    end
    #1;
    sweep(req);
  endtask

  task automatic reset_check();
    #1 rst_ni = 1'b0;
    #2;
    n_en = 0;
    for (int a = 0; a < DEPTH; a++) begin
      addr_i = 4'(a);
      #1;
      check("R1", q_o, 1'b0);
      check("R1", cascade_o, 1'b0);
    end
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    lfsr = 16'hACE1;
    reset_check();
    // R2/R7: continuous enable, walking-one then pseudo-random data
    step(1'b1, 1'b1, "R7");
    for (int i = 0; i < 20; i++) step(1'b1, 1'b0, "R2");
    for (int i = 0; i < 40; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(1'b1, lfsr[0], "R7");
    end
    // R3: held edges with toggling data must change nothing
    for (int i = 0; i < 8; i++) step(1'b0, i[0], "R3");
    // R7: enable gaps are not counted
    for (int i = 0; i < 80; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[3] | lfsr[5], lfsr[0], "R7");
    end
    // R1: clear mid-run, then refill from empty
    reset_check();
    for (int i = 0; i < 20; i++) step(1'b1, 1'b1, "R7");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule